// File: doc/BRIEF.md
# PWM Command Duty Meter

This block measures the duty cycle of a pulse-width-modulated speed command arriving from outside the chip. A single request arms it. It then waits for a falling edge of the command and counts clock cycles to the next rising edge, which gives the low time. It keeps counting to the next falling edge, which gives the full period. The high fraction is produced as a ratio of the two counts. A fixed error in the counting clock therefore scales both counts alike and cancels out of the result.

The command pin is asynchronous to the block clock, so it passes through a flop synchroniser before edge detection. Once the period is captured, a sequential divider produces an 8-bit duty value equal to `floor(high * 256 / period)`. The low time, period and duty are presented together with a one-cycle done pulse.

If an expected edge never comes, the block does not wait forever. The counter runs out, and the block reports a timeout with a duty of full scale or zero according to the level the input is stuck at. In the target system the meter runs once per motor commutation cycle, so a 25 kHz command against a 24 MHz count clock gives a period of 960.

Top module: `pwm_duty_meter`

## Requirements
- R1: After reset `low_cnt_o`, `period_o`, `duty_o`, `done_o` and `timeout_o` are all zero.
- R2: `start_i` is accepted only while the meter is idle. A start pulse during a measurement or during the division changes neither the outcome nor its timing.
- R3: After an accepted start, the meter waits for a falling edge of `cmd_i`. `low_cnt_o` equals the number of clock cycles the input then stays low before it rises.
- R4: `period_o` equals the number of clock cycles from that falling edge to the next falling edge; a 960-cycle waveform reports 960.
- R5: `duty_o` equals `floor((period - low) * 256 / period)`, limited to 255.
- R6: `done_o` is a single-cycle pulse. All result outputs update in the same cycle and hold until the next completion. For a normal measurement, counting the rising clock edge that first samples the closing falling edge of `cmd_i` as edge 1, `done_o` is high right after edge 12.
- R7: A measurement times out when either of two edges is missing. The first is the opening falling edge, if it has not been seen 65535 cycles after the start. The second is the closing falling edge, if it has not been seen 65535 cycles after the opening one. On a timeout, `done_o` pulses and `timeout_o` goes to 1. `low_cnt_o` and `period_o` read 0, and `duty_o` reads 255 if the synchronised input is high or 0 if it is low.
- R8: `timeout_o` holds its value until the next completion and is cleared by a completion without a timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Count clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 1 | Asynchronous PWM speed command |
| start_i | input | 1 | Request one measurement |
| low_cnt_o | output | 16 | Measured low time in cycles |
| period_o | output | 16 | Measured period in cycles |
| duty_o | output | 8 | High fraction, 256 = full scale |
| done_o | output | 1 | Result valid pulse |
| timeout_o | output | 1 | Last result ended in a timeout |

## Verification
A wrong state in the edge sequencer shows up at the ports as a done pulse in the wrong cycle, or as a low time or period off by whole edges. The bench compares every output on every clock against a behavioural model, so such an error is caught in the very cycle the pulse moves. An error in the divider's remainder path leaves the timing right but gives the wrong `duty_o` value in the done cycle. A counter that wraps or a timeout that fires early shows up either as a spurious `timeout_o` or as a done pulse 65535 cycles away from the predicted edge.

// File: rtl/pwm_duty_pkg.sv
package pwm_duty_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_FALL,
    ST_LOW,
    ST_HIGH,
    ST_DIV
  } meter_state_e;
endpackage

// File: rtl/pwm_duty_sync.sv
module pwm_duty_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= async_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[i] <= 1'b0;
        else         chain_q[i] <= chain_q[i-1];
    end
  end

  assign level_o = chain_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_o;

  assign rise_o = level_o & ~prev_q;
  assign fall_o = ~level_o & prev_q;
endmodule

// File: rtl/pwm_duty_div.sv
module pwm_duty_div #(
  parameter int NW = 16,
  parameter int QW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [NW-1:0] num_i,
  input  logic [NW-1:0] den_i,
  output logic [QW-1:0] q_o,
  output logic          done_o
);
  localparam int SW = $clog2(QW + 1);

  logic [NW:0]   rem_q, shifted, rem_nxt;
  logic [NW-1:0] den_q;
  logic [QW-1:0] q_q;
  logic [SW-1:0] step_q;
  logic          ge;

  // restoring division, one quotient bit per cycle; expects num < den
  assign shifted = {rem_q[NW-1:0], 1'b0};
  assign ge      = shifted >= {1'b0, den_q};
  assign rem_nxt = ge ? shifted - {1'b0, den_q} : shifted;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      q_q    <= '0;
      step_q <= '0;
      done_o <= 1'b0;
    end else if (start_i) begin
      rem_q  <= {1'b0, num_i};
      den_q  <= den_i;
      q_q    <= '0;
      step_q <= SW'(QW);
      done_o <= 1'b0;
    end else if (step_q != '0) begin
      rem_q  <= rem_nxt;
      q_q    <= {q_q[QW-2:0], ge};
      step_q <= step_q - SW'(1);
      done_o <= (step_q == SW'(1));
    end else begin
      done_o <= 1'b0;
    end
  end

  assign q_o = q_q;

  // R5: partial remainder stays below the divisor throughout the division
  assert_rem_below_den_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q != '0) |-> (rem_q < {1'b0, den_q}));
endmodule

// File: rtl/pwm_duty_meter.sv
module pwm_duty_meter
  import pwm_duty_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DUTY_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_i,
  input  logic              start_i,
  output logic [CNT_W-1:0]  low_cnt_o,
  output logic [CNT_W-1:0]  period_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic              done_o,
  output logic              timeout_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  meter_state_e      state_q;
  logic [CNT_W-1:0]  cnt_q, low_q, period_q, high_w;
  logic              sat_q;
  logic              level, rise, fall;
  logic              div_start, div_done, measuring;
  logic [DUTY_W-1:0] div_q;

  pwm_duty_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (cmd_i),
    .level_o (level),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  assign high_w    = cnt_q - low_q;
  assign div_start = (state_q == ST_HIGH) && fall;
  assign measuring = (state_q == ST_WAIT_FALL) || (state_q == ST_LOW) || (state_q == ST_HIGH);

  pwm_duty_div #(.NW(CNT_W), .QW(DUTY_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .num_i   (high_w),
    .den_i   (cnt_q),
    .q_o     (div_q),
    .done_o  (div_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      low_q     <= '0;
      period_q  <= '0;
      sat_q     <= 1'b0;
      low_cnt_o <= '0;
      period_o  <= '0;
      duty_o    <= '0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_WAIT_FALL;
          cnt_q   <= CNT_ONE;
        end
        ST_WAIT_FALL: begin
          if (fall) begin
            state_q <= ST_LOW;
            cnt_q   <= CNT_ONE;
          end else if (cnt_q == CNT_MAX) begin
            state_q   <= ST_IDLE;
            done_o    <= 1'b1;
            timeout_o <= 1'b1;
            duty_o    <= level ? '1 : '0;
            low_cnt_o <= '0;
            period_o  <= '0;
          end else cnt_q <= cnt_q + CNT_ONE;
        end
        ST_LOW: begin
          // a rise at the limit leaves no room for the period
          if (cnt_q == CNT_MAX) begin
            state_q   <= ST_IDLE;
            done_o    <= 1'b1;
            timeout_o <= 1'b1;
            duty_o    <= level ? '1 : '0;
            low_cnt_o <= '0;
            period_o  <= '0;
          end else begin
            if (rise) begin
              low_q   <= cnt_q;
              state_q <= ST_HIGH;
            end
            cnt_q <= cnt_q + CNT_ONE;
          end
        end
        ST_HIGH: begin
          if (fall) begin
            period_q <= cnt_q;
            sat_q    <= (high_w >= cnt_q);
            state_q  <= ST_DIV;
          end else if (cnt_q == CNT_MAX) begin
            state_q   <= ST_IDLE;
            done_o    <= 1'b1;
            timeout_o <= 1'b1;
            duty_o    <= level ? '1 : '0;
            low_cnt_o <= '0;
            period_o  <= '0;
          end else cnt_q <= cnt_q + CNT_ONE;
        end
        ST_DIV: if (div_done) begin
          state_q   <= ST_IDLE;
          done_o    <= 1'b1;
          timeout_o <= 1'b0;
          duty_o    <= sat_q ? '1 : div_q;
          low_cnt_o <= low_q;
          period_o  <= period_q;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_timeout_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> done_o);

  assert_timeout_duty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && timeout_o) |-> (duty_o == '0 || duty_o == '1));

  assert_low_below_period_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !timeout_o) |-> (low_cnt_o != '0 && low_cnt_o < period_o));

  assert_no_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    measuring |-> (cnt_q != '0));

  assert_start_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DIV && !div_done) |=> (state_q == ST_DIV || state_q == ST_IDLE));
endmodule

// File: tb/pwm_duty_meter_tb.sv
`timescale 1ns/1ps
module pwm_duty_meter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd = 1'b0;
  logic        start = 1'b0;
  logic [15:0] low_cnt, period;
  logic [7:0]  duty;
  logic        done, timeout;

  int checks = 0;
  int fails = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  pwm_duty_meter u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cmd_i     (cmd),
    .start_i   (start),
    .low_cnt_o (low_cnt),
    .period_o  (period),
    .duty_o    (duty),
    .done_o    (done),
    .timeout_o (timeout)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: sample history, phase tag, elapsed cycles
  int h[3];
  int ph;      // 0 idle, 1 await opening fall, 2 low, 3 high, 4 dividing
  int el, lo, per, dc, pend_duty;
  int e_done, e_low, e_per, e_duty, e_to;

  task automatic m_timeout(input int lvl);
    e_done = 1; e_to = 1; e_low = 0; e_per = 0;
    e_duty = lvl ? 255 : 0;
    ph = 0;
  endtask

  always @(posedge clk) begin
    int lvl, prv;
    bit f, r;
    if (!rst_n) begin
      h = '{0, 0, 0};
      ph = 0; el = 0; lo = 0; per = 0; dc = 0; pend_duty = 0;
      e_done = 0; e_low = 0; e_per = 0; e_duty = 0; e_to = 0;
    end else begin
      lvl = h[1];
      prv = h[2];
      f = (prv == 1) && (lvl == 0);
      r = (prv == 0) && (lvl == 1);
      e_done = 0;
      case (ph)
        0: if (start) begin ph = 1; el = 1; end
        1: if (f) begin ph = 2; el = 1; end
           else if (el == 65535) m_timeout(lvl);
           else el++;
        2: if (el == 65535) m_timeout(lvl);
           else begin
             if (r) begin lo = el; ph = 3; end
             el++;
           end
        3: if (f) begin
             per = el;
             pend_duty = ((per - lo) * 256) / per;
             if (pend_duty > 255) pend_duty = 255;
             ph = 4; dc = 9;
           end else if (el == 65535) m_timeout(lvl);
           else el++;
        4: begin
          dc--;
          if (dc == 0) begin
            e_done = 1; e_to = 0; e_low = lo; e_per = per; e_duty = pend_duty;
            ph = 0;
          end
        end
        default: ph = 0;
      endcase
      h[2] = h[1];
      h[1] = h[0];
      h[0] = int'(cmd);
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      chk("R6 done_o timing", int'(done), e_done);
      chk("R3 low_cnt_o", int'(low_cnt), e_low);
      chk("R4 period_o", int'(period), e_per);
      chk("R5 duty_o", int'(duty), e_duty);
      chk("R8 timeout_o", int'(timeout), e_to);
    end
  end

  task automatic run(input int l, input int hi, input bit mid_start);
    cmd = 1'b1;
    repeat (5) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    cmd = 1'b0;
    repeat (l) @(negedge clk);
    cmd = 1'b1;
    if (mid_start) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (hi - 1) @(negedge clk);
    end else begin
      repeat (hi) @(negedge clk);
    end
    cmd = 1'b0;
    repeat (16) @(negedge clk);
    cmd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 low_cnt_o", int'(low_cnt), 0);
    chk("R1 period_o", int'(period), 0);
    chk("R1 duty_o", int'(duty), 0);
    chk("R1 done_o", int'(done), 0);
    chk("R1 timeout_o", int'(timeout), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run(480, 480, 1'b0);  // R4: 960-cycle command
    chk("R4 period 960", int'(period), 960);
    chk("R3 low 480", int'(low_cnt), 480);
    chk("R5 duty half", int'(duty), 128);

    run(720, 240, 1'b0);
    chk("R5 duty quarter", int'(duty), 64);

    run(1, 1, 1'b0);
    chk("R3 low min", int'(low_cnt), 1);
    chk("R4 period min", int'(period), 2);
    chk("R5 duty min period", int'(duty), 128);

    run(3, 997, 1'b0);
    chk("R5 duty near full", int'(duty), 255);

    run(997, 3, 1'b0);
    chk("R5 duty near zero", int'(duty), 0);

    run(600, 400, 1'b1);  // R2: start during high phase ignored
    chk("R2 period kept", int'(period), 1000);
    chk("R2 duty kept", int'(duty), 102);

    // R7: input stuck high, no opening fall
    cmd = 1'b1;
    repeat (5) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (65545) @(negedge clk);
    chk("R7 timeout high flag", int'(timeout), 1);
    chk("R7 timeout high duty", int'(duty), 255);
    chk("R7 timeout high period", int'(period), 0);

    // R7: input stuck low after opening fall
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    cmd = 1'b0;
    repeat (65545) @(negedge clk);
    chk("R7 timeout low flag", int'(timeout), 1);
    chk("R7 timeout low duty", int'(duty), 0);
    chk("R7 timeout low lowcnt", int'(low_cnt), 0);

    run(100, 300, 1'b0);  // R8: clean completion clears the flag
    chk("R8 timeout cleared", int'(timeout), 0);
    chk("R5 duty three quarter", int'(duty), 192);

    finish_run();
  end
endmodule